// File: doc/BRIEF.md
# Segment Base-Limit Address Translator

This block turns a logical address, made of a segment number and an offset into that segment, into a physical address. It keeps a small table of segment descriptors. Each descriptor holds the physical start address of the segment and the segment's length. The segment number picks the descriptor. The offset is checked against the length. An offset that lies inside the segment is added to the start address to give the physical address. Any other offset is reported as an invalid-address error.

The table is filled through a write port, one descriptor per cycle. Translations are requested on a separate request port. Each request is answered exactly one cycle later. The answer is either a valid physical address or an error strobe, and never both. A segment number that points past the end of the table is also answered with an error. Software loads the table once per context, and the requester then issues one translation per cycle with no back-pressure.

Top module: `segt_translator`

## Requirements
- R1: After reset, rsp_valid_o, rsp_err_o and rsp_paddr_o are 0. Every descriptor starts with length 0, so any request made before a write returns an error.
- R2: When wr_en_i is high, the base wr_base_i and the length wr_limit_i are stored into descriptor wr_idx_i at the clock edge. Later requests to that segment use the stored values.
- R3: Take a request with req_valid_i high, req_seg_i below the segment count (8), and req_off_i strictly below the stored length. In the next cycle it gives rsp_valid_o=1, rsp_err_o=0 and rsp_paddr_o = base + offset.
- R4: A request whose offset is greater than or equal to the stored length gives rsp_err_o=1, rsp_valid_o=0 and rsp_paddr_o=0 in the next cycle.
- R5: A request with req_seg_i at or above the segment count (8 to 15 on a 4-bit field) gives rsp_err_o=1 in the next cycle, whatever the table holds.
- R6: rsp_valid_o and rsp_err_o are never high together. A cycle with req_valid_i low gives rsp_valid_o=0, rsp_err_o=0 and rsp_paddr_o=0 in the next cycle.
- R7: A write and a request to the same segment in the same cycle: the request is translated with the descriptor contents from before the write.
- R8: The sum base + offset is taken modulo 2^20. A carry out of the 20-bit physical address is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Descriptor write strobe |
| wr_idx_i | input | 3 | Descriptor index to write |
| wr_base_i | input | 20 | Segment start address to store |
| wr_limit_i | input | 16 | Segment length to store |
| req_valid_i | input | 1 | Translation request strobe |
| req_seg_i | input | 4 | Segment number of the logical address |
| req_off_i | input | 16 | Offset within the segment |
| rsp_valid_o | output | 1 | Translation succeeded, address valid |
| rsp_err_o | output | 1 | Invalid-address error |
| rsp_paddr_o | output | 20 | Physical address (0 unless rsp_valid_o) |

## Verification
Each request is answered one cycle after it is presented, and a descriptor write takes effect for requests presented from the cycle after the write. The bench drives inputs on the falling edge. It computes the expected response from a table model held before that cycle's write is applied. It then compares all three outputs on the following falling edge, so every clock cycle is checked, including idle ones. The corner cases are an offset equal to the length, a segment number past the table, address wrap-around, and a write that collides with a request. Each of these has a directed cycle.

// File: rtl/segt_pkg.sv
package segt_pkg;
  localparam int unsigned NUM_SEGS = 8;
  localparam int unsigned SEG_W    = 4;
  localparam int unsigned OFF_W    = 16;
  localparam int unsigned BASE_W   = 20;
  localparam int unsigned IDX_W    = $clog2(NUM_SEGS);

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic [OFF_W-1:0]  limit;
  } seg_desc_t;
endpackage

// File: rtl/segt_table.sv
module segt_table
  import segt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  seg_desc_t        wr_desc_i,
  input  logic [SEG_W-1:0] rd_seg_i,
  output logic             rd_hit_o,
  output seg_desc_t        rd_desc_o
);
  seg_desc_t tbl_q [NUM_SEGS];

  for (genvar g = 0; g < NUM_SEGS; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   tbl_q[g] <= '0;
      else if (wr_en_i && (32'(wr_idx_i) == 32'(g))) tbl_q[g] <= wr_desc_i;
    end
  end

  // Read mux; an out-of-table segment selects nothing.
  always_comb begin
    rd_hit_o  = 1'b0;
    rd_desc_o = '0;
    for (int i = 0; i < NUM_SEGS; i++) begin
      if (32'(rd_seg_i) == 32'(i)) begin
        rd_hit_o  = 1'b1;
        rd_desc_o = tbl_q[i];
      end
    end
  end
endmodule

// File: rtl/segt_check.sv
module segt_check
  import segt_pkg::*;
(
  input  logic              req_valid_i,
  input  logic              seg_hit_i,
  input  seg_desc_t         desc_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic              ok_o,
  output logic              err_o,
  output logic [BASE_W-1:0] paddr_o
);
  logic in_seg;
  assign in_seg  = seg_hit_i && (off_i < desc_i.limit);
  assign ok_o    = req_valid_i && in_seg;
  assign err_o   = req_valid_i && !in_seg;
  // Modulo 2^BASE_W sum; carry dropped.
  assign paddr_o = ok_o ? (desc_i.base + BASE_W'(off_i)) : '0;
endmodule

// File: rtl/segt_resp.sv
module segt_resp
  import segt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ok_i,
  input  logic              err_i,
  input  logic [BASE_W-1:0] paddr_i,
  output logic              valid_o,
  output logic              err_o,
  output logic [BASE_W-1:0] paddr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      err_o   <= 1'b0;
      paddr_o <= '0;
    end else begin
      valid_o <= ok_i;
      err_o   <= err_i;
      paddr_o <= paddr_i;
    end
  end

  p_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && err_o));
endmodule

// File: rtl/segt_translator.sv
module segt_translator
  import segt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [BASE_W-1:0] wr_base_i,
  input  logic [OFF_W-1:0]  wr_limit_i,
  input  logic              req_valid_i,
  input  logic [SEG_W-1:0]  req_seg_i,
  input  logic [OFF_W-1:0]  req_off_i,
  output logic              rsp_valid_o,
  output logic              rsp_err_o,
  output logic [BASE_W-1:0] rsp_paddr_o
);
  seg_desc_t         wr_desc, rd_desc;
  logic              seg_hit, chk_ok, chk_err;
  logic [BASE_W-1:0] chk_paddr;

  assign wr_desc = '{base: wr_base_i, limit: wr_limit_i};

  segt_table u_table (
    .clk_i, .rst_ni, .wr_en_i, .wr_idx_i,
    .wr_desc_i(wr_desc), .rd_seg_i(req_seg_i),
    .rd_hit_o(seg_hit), .rd_desc_o(rd_desc)
  );

  segt_check u_check (
    .req_valid_i, .seg_hit_i(seg_hit), .desc_i(rd_desc), .off_i(req_off_i),
    .ok_o(chk_ok), .err_o(chk_err), .paddr_o(chk_paddr)
  );

  segt_resp u_resp (
    .clk_i, .rst_ni, .ok_i(chk_ok), .err_i(chk_err), .paddr_i(chk_paddr),
    .valid_o(rsp_valid_o), .err_o(rsp_err_o), .paddr_o(rsp_paddr_o)
  );

  p_answer_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (rsp_valid_o || rsp_err_o));
  p_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!rsp_valid_o && !rsp_err_o && rsp_paddr_o == '0));
  p_seg_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && 32'(req_seg_i) >= 32'(NUM_SEGS)) |=> rsp_err_o);
  p_err_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> rsp_paddr_o == '0);
endmodule

// File: tb/segt_translator_tb_top.sv
module segt_translator_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_idx_i = '0;
  logic [19:0] wr_base_i = '0;
  logic [15:0] wr_limit_i = '0;
  logic        req_valid_i = 1'b0;
  logic [3:0]  req_seg_i = '0;
  logic [15:0] req_off_i = '0;
  logic        rsp_valid_o, rsp_err_o;
  logic [19:0] rsp_paddr_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int m_base [8];
  int m_lim  [8];

  always #2.5 clk_i = ~clk_i;

  segt_translator dut_i (.*);

  task automatic compare(input bit ev, input bit ee, input int ep, input string tag);
    n_chk++;
    if (rsp_valid_o !== ev || rsp_err_o !== ee || rsp_paddr_o !== 20'(ep)) begin
      n_bad++;
      $display("FAIL %s: got valid=%0b err=%0b paddr=%0d, exp valid=%0b err=%0b paddr=%0d",
               tag, rsp_valid_o, rsp_err_o, rsp_paddr_o, ev, ee, ep);
    end
  endtask

  // One clock: drive at negedge, model, compare at the next negedge.
  task automatic cyc(input bit we, input int wi, input int wb, input int wl,
                     input bit rv, input int rs, input int ro, input string tag);
    bit ev = 0, ee = 0;
    int ep = 0;
    wr_en_i = we; wr_idx_i = 3'(wi); wr_base_i = 20'(wb); wr_limit_i = 16'(wl);
    req_valid_i = rv; req_seg_i = 4'(rs); req_off_i = 16'(ro);
    if (rv) begin
      if (rs < 8 && ro < m_lim[rs]) begin
        ev = 1; ep = (m_base[rs] + ro) % (1 << 20);
      end else ee = 1;
    end
    if (we) begin m_base[wi] = wb; m_lim[wi] = wl; end
    @(negedge clk_i);
    compare(ev, ee, ep, tag);
  endtask

  task automatic wr(input int i, input int b, input int l);
    cyc(1, i, b, l, 0, 0, 0, "R2/R6 idle during write");
  endtask

  task automatic rq(input int s, input int o, input string tag);
    cyc(0, 0, 0, 0, 1, s, o, tag);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin m_base[i] = 0; m_lim[i] = 0; end
    @(negedge clk_i);
    compare(0, 0, 0, "R1 reset outputs");
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare(0, 0, 0, "R1 after reset release");
    rq(0, 0, "R1 empty table errors");
    rq(7, 0, "R1 empty table errors");
    wr(0, 5432, 350); wr(1, 115, 100); wr(2, 2200, 780);
    wr(3, 4235, 1100); wr(4, 1650, 400);
    rq(2, 247, "R3 seg2 off247");
    rq(4, 439, "R4 seg4 off above length");
    rq(4, 400, "R4 seg4 off equal length");
    rq(4, 399, "R3 seg4 last byte");
    rq(1, 99, "R3 seg1");
    rq(0, 349, "R3 seg0");
    rq(3, 0, "R3 seg3 off0");
    rq(5, 0, "R4 unwritten seg length 0");
    rq(8, 0, "R5 seg past table");
    rq(15, 10, "R5 seg 15");
    cyc(0, 0, 0, 0, 0, 2, 5, "R6 no request");
    cyc(1, 3, 100, 5, 1, 3, 1000, "R7 request sees old descriptor");
    rq(3, 1000, "R7 new descriptor now applies");
    rq(3, 4, "R2 rewritten seg3");
    wr(6, 20'hFFFF0, 16'hFFFF);
    rq(6, 32, "R8 wrap modulo 2^20");
    rq(6, 15, "R8 no wrap below top");
    for (int k = 0; k < 40; k++)
      cyc(k % 5 == 0, k % 8, k * 977, (k * 131) % 700, k % 3 != 0, k % 11, (k * 53) % 800,
          "R3/R4/R5 mixed stream");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule